// File: doc/BRIEF.md
# DMA channel synchronization sequencer

This block sequences one logical DMA channel. Software programs the whole channel in a single write strobe: the element size, the number of elements in a frame, the number of frames in the block, a packet length, two synchronization bits, the side that raises packet requests, and an addressing mode and start address for each side. Each hardware request then moves a number of elements that depends on the synchronization bits. The choices are a single element, the rest of the current frame, the rest of the block, or one packet.

Each element is moved as a read command on the source side and then a write command on the destination side. Each command is a valid signal with an address, and it is held until the matching ready is seen. After every element the sequencer steps the addresses and updates its element, frame and packet counts. When the final element of the final frame has been written, the channel turns itself off and flags completion. Software can stop the channel at any time by writing the configuration with the enable bit clear.

Top module: `dma_sync_seq`

## Requirements
- R1: During and after reset, until the first configuration write, `en_o`, `busy_o`, `rd_valid_o`, `wr_valid_o` and `block_done_o` are all low.
- R2: The edge that samples `cfg_we_i` high does all of the following: it loads every configuration field, sets `en_o` from `cfg_en_i`, returns the address outputs to the programmed start addresses, restarts the element, frame and packet counts, drops any pending request and abandons any element in progress.
- R3: An element starts with `rd_valid_o` high and `rd_addr_o` steady until `rd_ready_i` is sampled high. `wr_valid_o` then rises on the next cycle and stays high, with `wr_addr_o` steady, until `wr_ready_i` is sampled high. The two valids are never high together.
- R4: With {`cfg_fs_i`,`cfg_bs_i`} = 2'b00, each request moves exactly one element.
- R5: With {fs,bs} = 2'b10, a request moves elements up to and including the last element of the current frame.
- R6: With {fs,bs} = 2'b01, one request moves every remaining element of the block.
- R7: With {fs,bs} = 2'b11, a request moves the programmed packet count of elements, or fewer if the block ends first. A packet may run across a frame boundary.
- R8: A side whose addressing mode is 2'b01 advances its address after each element by 1, 2 or 4 bytes for element size 0, 1 or 2. Element size 3 steps by 4. Any other mode code keeps the address constant.
- R9: In packet mode, `cfg_pkt_src_i`=1 keeps the source address constant and `cfg_pkt_src_i`=0 keeps the destination address constant, whatever the programmed mode of that side.
- R10: A request that is not served at once is kept as one pending request. This covers a request that arrives while busy, including one in the cycle that completes a burst. Any number of such requests merge into one. The pending request starts a burst on the first idle cycle.
- R11: When the write of the last element of the last frame completes, `en_o` clears and `block_done_o` is high for exactly that one following cycle. Any pending request is dropped.
- R12: A configuration write with `cfg_en_i`=0 stops the channel: both valids and `busy_o` are low on the next cycle. While the channel is disabled, requests are ignored.
- R13: An element, frame or packet count programmed as zero behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Channel enable value |
| cfg_fs_i | input | 1 | Synchronization bit, frame |
| cfg_bs_i | input | 1 | Synchronization bit, block |
| cfg_pkt_src_i | input | 1 | Packet requestor is the source (1) or the destination (0) |
| cfg_esize_i | input | 2 | Element size code |
| cfg_elems_i | input | EW (24) | Elements per frame |
| cfg_frames_i | input | FW (16) | Frames per block |
| cfg_pkt_elems_i | input | PW (16) | Elements per packet |
| cfg_src_amode_i | input | 2 | Source addressing mode |
| cfg_dst_amode_i | input | 2 | Destination addressing mode |
| cfg_src_addr_i | input | AW (32) | Source start address |
| cfg_dst_addr_i | input | AW (32) | Destination start address |
| dma_req_i | input | 1 | Hardware DMA request |
| rd_valid_o | output | 1 | Read command valid |
| rd_addr_o | output | AW (32) | Read address |
| rd_ready_i | input | 1 | Read completion |
| wr_valid_o | output | 1 | Write command valid |
| wr_addr_o | output | AW (32) | Write address |
| wr_ready_i | input | 1 | Write completion |
| en_o | output | 1 | Channel enabled |
| busy_o | output | 1 | A burst is in progress |
| block_done_o | output | 1 | One-cycle pulse when the block completes |

## Verification
Two events can fall in the same cycle: a new request, and the write completion that ends a burst. The bench sets ready permanently high in frame mode. It watches for the write of the last element in a frame and raises the request on exactly that cycle. The expected result is one idle cycle with `busy_o` low, and then a new read on the next cycle with no further request. Requests that arrive back to back while busy are checked to merge into one extra burst. A cycle-by-cycle reference model checks every output on every clock while the ready inputs are randomized.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;
  // encoded as {fs, bs}
  typedef enum logic [1:0] {
    SYNC_ELEM  = 2'b00,
    SYNC_BLOCK = 2'b01,
    SYNC_FRAME = 2'b10,
    SYNC_PKT   = 2'b11
  } sync_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RD   = 2'b01,
    ST_WR   = 2'b10
  } seq_state_e;

  localparam logic [1:0] AMODE_INC = 2'b01;
  localparam int unsigned NSIDE = 2;

  function automatic logic [2:0] esize_step(input logic [1:0] es);
    case (es)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [2:0]    step_i,
  input  logic          inc_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [2:0]    step_q;
  logic          inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      step_q <= '0;
      inc_q  <= 1'b0;
    end else if (load_i) begin
      addr_q <= base_i;
      step_q <= step_i;
      inc_q  <= inc_i;
    end else if (adv_i && inc_q) begin
      addr_q <= addr_q + AW'(step_q);
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int unsigned EW = 24,
  parameter int unsigned FW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [EW-1:0] elems_i,
  input  logic [FW-1:0] frames_i,
  input  logic [PW-1:0] pkt_i,
  input  logic          start_i,
  input  logic          adv_i,
  output logic          last_frame_o,
  output logic          last_block_o,
  output logic          pkt_last_o
);
  logic [EW-1:0] elems_q, elem_left_q;
  logic [FW-1:0] frame_left_q;
  logic [PW-1:0] pkt_q, budget_q;

  assign last_frame_o = (elem_left_q == EW'(1));
  assign last_block_o = last_frame_o && (frame_left_q == FW'(1));
  assign pkt_last_o   = (budget_q == PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elems_q      <= '0;
      elem_left_q  <= '0;
      frame_left_q <= '0;
      pkt_q        <= '0;
      budget_q     <= '0;
    end else if (load_i) begin
      elems_q      <= elems_i;
      elem_left_q  <= elems_i;
      frame_left_q <= frames_i;
      pkt_q        <= pkt_i;
      budget_q     <= '0;
    end else if (start_i) begin
      budget_q <= pkt_q;
    end else if (adv_i) begin
      budget_q <= budget_q - PW'(1);
      if (last_frame_o) begin
        elem_left_q  <= elems_q;
        frame_left_q <= frame_left_q - FW'(1);
      end else begin
        elem_left_q <= elem_left_q - EW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_sync_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic       cfg_en_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       req_i,
  input  logic       rd_ready_i,
  input  logic       wr_ready_i,
  input  logic       last_frame_i,
  input  logic       last_block_i,
  input  logic       pkt_last_i,
  output seq_state_e state_o,
  output logic       start_o,
  output logic       adv_o,
  output logic       en_o,
  output logic       done_o
);
  seq_state_e state_q;
  sync_mode_e mode_q;
  logic       en_q, pend_q, done_q;
  logic       take, burst_end, pend_n;

  always_comb begin
    take      = en_q && (state_q == ST_IDLE) && (req_i || pend_q);
    start_o   = take && !cfg_we_i;
    adv_o     = (state_q == ST_WR) && wr_ready_i && !cfg_we_i;
    burst_end = last_block_i
             || (mode_q == SYNC_ELEM)
             || ((mode_q == SYNC_FRAME) && last_frame_i)
             || ((mode_q == SYNC_PKT) && pkt_last_i);
    // one pending slot; a request used to start this cycle is not kept
    pend_n    = (pend_q && !take) || (req_i && !(take && !pend_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= SYNC_ELEM;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (cfg_we_i) begin
      state_q <= ST_IDLE;
      mode_q  <= sync_mode_e'(cfg_mode_i);
      en_q    <= cfg_en_i;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_q) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_n;
        unique case (state_q)
          ST_IDLE: if (take) state_q <= ST_RD;
          ST_RD:   if (rd_ready_i) state_q <= ST_WR;
          ST_WR: begin
            if (wr_ready_i) begin
              if (last_block_i) begin
                state_q <= ST_IDLE;
                en_q    <= 1'b0;
                done_q  <= 1'b1;
                pend_q  <= 1'b0;
              end else if (burst_end) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_RD;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign en_o    = en_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dma_sync_seq.sv
module dma_sync_seq
  import dma_sync_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned EW = 24,
  parameter int unsigned FW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  logic          cfg_fs_i,
  input  logic          cfg_bs_i,
  input  logic          cfg_pkt_src_i,
  input  logic [1:0]    cfg_esize_i,
  input  logic [EW-1:0] cfg_elems_i,
  input  logic [FW-1:0] cfg_frames_i,
  input  logic [PW-1:0] cfg_pkt_elems_i,
  input  logic [1:0]    cfg_src_amode_i,
  input  logic [1:0]    cfg_dst_amode_i,
  input  logic [AW-1:0] cfg_src_addr_i,
  input  logic [AW-1:0] cfg_dst_addr_i,
  input  logic          dma_req_i,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ready_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  input  logic          wr_ready_i,
  output logic          en_o,
  output logic          busy_o,
  output logic          block_done_o
);
  logic [EW-1:0] elems_ld;
  logic [FW-1:0] frames_ld;
  logic [PW-1:0] pkt_ld;
  logic          pkt_mode;
  logic [2:0]    step;
  logic          start, adv, last_frame, last_block, pkt_last;
  seq_state_e    state;

  logic [NSIDE-1:0]         side_inc;
  logic [NSIDE-1:0]         side_amode_inc;
  logic [NSIDE-1:0]         side_held;
  logic [NSIDE-1:0][AW-1:0] side_base, side_addr;

  // zero counts behave as one
  assign elems_ld  = (cfg_elems_i     == '0) ? EW'(1) : cfg_elems_i;
  assign frames_ld = (cfg_frames_i    == '0) ? FW'(1) : cfg_frames_i;
  assign pkt_ld    = (cfg_pkt_elems_i == '0) ? PW'(1) : cfg_pkt_elems_i;
  assign pkt_mode  = cfg_fs_i && cfg_bs_i;
  assign step      = esize_step(cfg_esize_i);

  // side 0 = source (read), side 1 = destination (write)
  assign side_base[0]      = cfg_src_addr_i;
  assign side_base[1]      = cfg_dst_addr_i;
  assign side_amode_inc[0] = (cfg_src_amode_i == AMODE_INC);
  assign side_amode_inc[1] = (cfg_dst_amode_i == AMODE_INC);
  assign side_held[0]      = pkt_mode && cfg_pkt_src_i;
  assign side_held[1]      = pkt_mode && !cfg_pkt_src_i;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    assign side_inc[s] = side_amode_inc[s] && !side_held[s];
    dma_addr_gen #(.AW(AW)) u_agen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cfg_we_i),
      .base_i (side_base[s]),
      .step_i (step),
      .inc_i  (side_inc[s]),
      .adv_i  (adv),
      .addr_o (side_addr[s])
    );
  end

  dma_xfer_count #(.EW(EW), .FW(FW), .PW(PW)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (cfg_we_i),
    .elems_i      (elems_ld),
    .frames_i     (frames_ld),
    .pkt_i        (pkt_ld),
    .start_i      (start),
    .adv_i        (adv),
    .last_frame_o (last_frame),
    .last_block_o (last_block),
    .pkt_last_o   (pkt_last)
  );

  dma_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_en_i     (cfg_en_i),
    .cfg_mode_i   ({cfg_fs_i, cfg_bs_i}),
    .req_i        (dma_req_i),
    .rd_ready_i   (rd_ready_i),
    .wr_ready_i   (wr_ready_i),
    .last_frame_i (last_frame),
    .last_block_i (last_block),
    .pkt_last_i   (pkt_last),
    .state_o      (state),
    .start_o      (start),
    .adv_o        (adv),
    .en_o         (en_o),
    .done_o       (block_done_o)
  );

  assign rd_valid_o = (state == ST_RD);
  assign wr_valid_o = (state == ST_WR);
  assign busy_o     = (state != ST_IDLE);
  assign rd_addr_o  = side_addr[0];
  assign wr_addr_o  = side_addr[1];
endmodule

// File: rtl/dma_sync_seq_chk.sv
module dma_sync_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          cfg_en_i,
  input logic          rd_valid_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ready_i,
  input logic          wr_valid_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_ready_i,
  input logic          en_o,
  input logic          busy_o,
  input logic          block_done_o
);
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o)); // R3
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i && !cfg_we_i |=> rd_valid_o && $stable(rd_addr_o)); // R3
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i && !cfg_we_i |=> wr_valid_o && $stable(wr_addr_o)); // R3
  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_ready_i && !cfg_we_i |=> wr_valid_o); // R3
  AST_DONE_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> !en_o && !busy_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |=> !block_done_o); // R11
  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !busy_o); // R12
  AST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_en_i |=> !rd_valid_o && !wr_valid_o && !en_o); // R12
endmodule

bind dma_sync_seq dma_sync_seq_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_en_i     (cfg_en_i),
  .rd_valid_o   (rd_valid_o),
  .rd_addr_o    (rd_addr_o),
  .rd_ready_i   (rd_ready_i),
  .wr_valid_o   (wr_valid_o),
  .wr_addr_o    (wr_addr_o),
  .wr_ready_i   (wr_ready_i),
  .en_o         (en_o),
  .busy_o       (busy_o),
  .block_done_o (block_done_o)
);

// File: tb/dma_sync_seq_tb_top.sv
module dma_sync_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 0, cfg_en = 0, cfg_fs = 0, cfg_bs = 0, cfg_psrc = 0;
  logic [1:0]  cfg_es = 0, cfg_sam = 0, cfg_dam = 0;
  logic [23:0] cfg_el = 0;
  logic [15:0] cfg_fr = 0, cfg_pk = 0;
  logic [31:0] cfg_sa = 0, cfg_da = 0;
  logic        req = 0, rd_rdy = 0, wr_rdy = 0;
  logic        rd_v, wr_v, en, busy, done;
  logic [31:0] rd_a, wr_a;

  dma_sync_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .cfg_fs_i(cfg_fs), .cfg_bs_i(cfg_bs), .cfg_pkt_src_i(cfg_psrc),
    .cfg_esize_i(cfg_es), .cfg_elems_i(cfg_el), .cfg_frames_i(cfg_fr),
    .cfg_pkt_elems_i(cfg_pk), .cfg_src_amode_i(cfg_sam), .cfg_dst_amode_i(cfg_dam),
    .cfg_src_addr_i(cfg_sa), .cfg_dst_addr_i(cfg_da), .dma_req_i(req),
    .rd_valid_o(rd_v), .rd_addr_o(rd_a), .rd_ready_i(rd_rdy),
    .wr_valid_o(wr_v), .wr_addr_o(wr_a), .wr_ready_i(wr_rdy),
    .en_o(en), .busy_o(busy), .block_done_o(done)
  );

  int checks = 0, failures = 0, cyc = 0, hs = 0;
  bit rdy_rand = 0, s_wrv = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0]  m_mode;
  logic [31:0] m_src, m_dst;
  int          m_step, m_elems, m_pkt, m_el_left, m_fr_left, m_bud, m_st;
  bit          m_sinc, m_dinc, m_en, m_pend, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_src = 0; m_dst = 0; m_step = 0; m_elems = 0; m_pkt = 0;
      m_el_left = 0; m_fr_left = 0; m_bud = 0; m_st = 0;
      m_sinc = 0; m_dinc = 0; m_en = 0; m_pend = 0; m_done = 0;
    end else if (cfg_we) begin
      m_mode = {cfg_fs, cfg_bs};
      m_src = cfg_sa; m_dst = cfg_da;
      m_step = (cfg_es == 0) ? 1 : (cfg_es == 1) ? 2 : 4;
      m_sinc = (cfg_sam == 2'b01) && !(m_mode == 3 && cfg_psrc);
      m_dinc = (cfg_dam == 2'b01) && !(m_mode == 3 && !cfg_psrc);
      m_elems = (cfg_el == 0) ? 1 : int'(cfg_el);
      m_fr_left = (cfg_fr == 0) ? 1 : int'(cfg_fr);
      m_pkt = (cfg_pk == 0) ? 1 : int'(cfg_pk);
      m_el_left = m_elems; m_bud = 0;
      m_en = cfg_en; m_st = 0; m_pend = 0; m_done = 0;
    end else begin
      bit take, fin, lastfr, lastblk, bend;
      m_done = 0; fin = 0;
      if (!m_en) m_pend = 0;
      else begin
        take = (m_st == 0) && (req || m_pend);
        case (m_st)
          0: if (take) begin m_st = 1; m_bud = (m_mode == 3) ? m_pkt : 0; end
          1: if (rd_rdy) m_st = 2;
          default: if (wr_rdy) begin
            lastfr = (m_el_left == 1);
            lastblk = lastfr && (m_fr_left == 1);
            bend = lastblk || m_mode == 0 || (m_mode == 2 && lastfr) || (m_mode == 3 && m_bud == 1);
            if (m_sinc) m_src += m_step;
            if (m_dinc) m_dst += m_step;
            m_bud--;
            if (lastfr) begin m_el_left = m_elems; m_fr_left--; end
            else m_el_left--;
            if (lastblk) begin m_en = 0; m_done = 1; m_st = 0; fin = 1; end
            else m_st = bend ? 0 : 1;
          end
        endcase
        if (fin) m_pend = 0;
        else m_pend = (m_pend && !take) || (req && !(take && !m_pend));
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(rd_v == (m_st == 1), "R3 rd_valid", rd_v, m_st == 1);
    chk(wr_v == (m_st == 2), "R3 wr_valid", wr_v, m_st == 2);
    chk(busy == (m_st != 0), "R10 busy", busy, m_st != 0);
    chk(rd_a == m_src, "R8 rd_addr", rd_a, m_src);
    chk(wr_a == m_dst, "R8 wr_addr", wr_a, m_dst);
    chk(en == m_en, "R11 en", en, m_en);
    chk(done == m_done, "R11 block_done", done, m_done);
  end

  // ready drivers and write handshake counter
  always @(negedge clk) begin
    s_wrv <= wr_v;
    rd_rdy <= rdy_rand ? 1'($urandom % 2) : 1'b1;
    wr_rdy <= rdy_rand ? 1'($urandom % 2) : 1'b1;
  end
  always @(posedge clk) if (rst_n && s_wrv && wr_rdy && !cfg_we) hs++;

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic prog(input bit fs, bs, input logic [1:0] es, input int el, fr, pk,
                      input bit psrc, input logic [1:0] sam, dam,
                      input logic [31:0] sa, da, input bit e);
    @(negedge clk);
    cfg_fs = fs; cfg_bs = bs; cfg_es = es; cfg_el = 24'(el); cfg_fr = 16'(fr);
    cfg_pk = 16'(pk); cfg_psrc = psrc; cfg_sam = sam; cfg_dam = dam;
    cfg_sa = sa; cfg_da = da; cfg_en = e; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_hs(input int n);
    for (int i = 0; i < 3000 && hs < n; i++) @(negedge clk);
  endtask

  initial begin
    int h0;
    bit saw_done;
    repeat (3) @(negedge clk);
    chk(!en && !busy && !rd_v && !wr_v && !done, "R1 reset outputs", {en, busy, rd_v, wr_v, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!en && !busy && !rd_v && !wr_v && !done, "R1 after reset", {en, busy, rd_v, wr_v, done}, 0);

    // element sync
    rdy_rand = 1;
    prog(0, 0, 2'd2, 3, 2, 1, 0, 2'b01, 2'b01, 32'h1000, 32'h2000, 1);
    chk(en && !busy && rd_a == 32'h1000 && wr_a == 32'h2000, "R2 load", rd_a, 32'h1000);
    for (int k = 0; k < 6; k++) begin
      h0 = hs; pulse_req(); wait_idle();
      chk(hs - h0 == 1, "R4 one element per request", hs - h0, 1);
    end
    chk(!en, "R11 disabled after block", en, 0);
    chk(rd_a == 32'h1018 && wr_a == 32'h2018, "R8 step 4", rd_a, 32'h1018);

    // frame sync, three requests merge into two bursts
    prog(1, 0, 2'd1, 4, 3, 1, 0, 2'b01, 2'b00, 32'h100, 32'h800, 1);
    h0 = hs;
    pulse_req(); pulse_req(); pulse_req();
    wait_hs(h0 + 8);
    repeat (4) @(negedge clk);
    chk(hs - h0 == 8 && !busy, "R10 merged pending, R5 frame bursts", hs - h0, 8);
    chk(wr_a == 32'h800, "R8 constant dst", wr_a, 32'h800);
    pulse_req(); wait_idle();
    chk(hs - h0 == 12 && !en, "R5 last frame ends block", hs - h0, 12);
    chk(rd_a == 32'h118, "R8 step 2", rd_a, 32'h118);

    // block sync
    prog(0, 1, 2'd0, 5, 2, 1, 0, 2'b01, 2'b01, 32'h40, 32'h80, 1);
    h0 = hs; saw_done = 0;
    pulse_req();
    for (int i = 0; i < 3000 && en; i++) begin @(negedge clk); if (done) saw_done = 1; end
    chk(hs - h0 == 10, "R6 whole block", hs - h0, 10);
    chk(saw_done, "R11 done pulse", saw_done, 1);
    chk(rd_a == 32'h4A && wr_a == 32'h8A, "R8 step 1", rd_a, 32'h4A);

    // packet, source requestor
    prog(1, 1, 2'd2, 4, 2, 3, 1, 2'b01, 2'b01, 32'h3000, 32'h4000, 1);
    h0 = hs; pulse_req(); wait_idle();
    chk(hs - h0 == 3, "R7 packet of 3", hs - h0, 3);
    h0 = hs; pulse_req(); wait_idle();
    chk(hs - h0 == 3 && en, "R7 packet across frame", hs - h0, 3);
    h0 = hs; pulse_req(); wait_idle();
    chk(hs - h0 == 2 && !en, "R7 truncated last packet", hs - h0, 2);
    chk(rd_a == 32'h3000, "R9 src held", rd_a, 32'h3000);
    chk(wr_a == 32'h4020, "R9 dst advances", wr_a, 32'h4020);

    // packet, destination requestor
    prog(1, 1, 2'd1, 3, 3, 5, 0, 2'b01, 2'b01, 32'h5000, 32'h6000, 1);
    h0 = hs; pulse_req(); wait_idle();
    chk(hs - h0 == 5, "R7 packet of 5", hs - h0, 5);
    pulse_req(); wait_idle();
    chk(hs - h0 == 9 && !en, "R7 remainder", hs - h0, 9);
    chk(wr_a == 32'h6000 && rd_a == 32'h5012, "R9 dst held", wr_a, 32'h6000);

    // disable mid transfer
    prog(0, 1, 2'd2, 100, 1, 1, 0, 2'b01, 2'b01, 32'h0, 32'h0, 1);
    pulse_req();
    repeat (10) @(negedge clk);
    chk(busy, "R12 running before stop", busy, 1);
    prog(0, 1, 2'd2, 100, 1, 1, 0, 2'b01, 2'b01, 32'h0, 32'h0, 0);
    chk(!rd_v && !wr_v && !busy && !en, "R12 stop", {rd_v, wr_v, busy, en}, 0);
    h0 = hs; pulse_req(); repeat (5) @(negedge clk);
    chk(hs == h0 && !busy, "R12 request ignored when off", hs - h0, 0);

    // zero counts
    prog(0, 1, 2'd0, 0, 0, 0, 0, 2'b01, 2'b01, 32'h10, 32'h20, 1);
    h0 = hs; pulse_req(); wait_idle();
    chk(hs - h0 == 1 && !en, "R13 zero elems/frames", hs - h0, 1);
    prog(1, 1, 2'd0, 2, 1, 0, 1, 2'b00, 2'b01, 32'h10, 32'h20, 1);
    h0 = hs; pulse_req(); wait_idle();
    chk(hs - h0 == 1 && en, "R13 zero packet", hs - h0, 1);

    // request coinciding with burst-ending write
    rdy_rand = 0;
    repeat (2) @(negedge clk);
    prog(1, 0, 2'd0, 2, 3, 1, 0, 2'b01, 2'b01, 32'h0, 32'h0, 1);
    h0 = hs; pulse_req();
    for (int i = 0; i < 100 && !(wr_v && hs == h0 + 1); i++) @(negedge clk);
    req = 1;
    @(negedge clk); req = 0;
    chk(!busy, "R10 idle cycle after burst", busy, 0);
    @(negedge clk);
    chk(rd_v, "R10 coincident request served", rd_v, 1);
    wait_idle();
    chk(hs - h0 == 4 && en, "R10 second frame only", hs - h0, 4);
    pulse_req(); wait_idle();
    chk(hs - h0 == 6 && !en, "R5 block finished", hs - h0, 6);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule